// File: doc/BRIEF.md
# Supervisor Reset Controller with Watchdog

This block is the reset supervisor of a small processor system. It watches three reset causes: an active-low undervoltage flag from an external comparator, an active-low pushbutton, and a watchdog that the processor feeds through a strobe input. Any active cause forces the system reset on. Once every cause has gone away, the reset is held for a fixed stretch so that clocks and supplies can settle before software runs.

The logic is clocked by a slow timebase. One clock is taken to be one millisecond, so the default counts are given in milliseconds. Every count is a parameter, which lets a bench shorten the time scale. The pushbutton passes through a filter that needs an unbroken run of low samples before it is accepted. The strobe is synchronised, and only its falling edge restarts the watchdog. A two-bit select chooses one of three watchdog timeouts. A single stretcher produces the reset for every cause, and the reset drives a true output and a complementary output.

Top module: `supervisor_reset_ctrl`

## Requirements
- R1: While `rst` is high the reset output is asserted. After `rst` falls, with no other cause active, the reset stays asserted for exactly HOLD_MS clock edges and is then released.
- R2: `sys_reset_n` is always the inverse of `sys_reset`.
- R3: A low `uv_n` asserts the reset at the next clock edge, and the reset stays asserted for as long as `uv_n` is low.
- R4: After the last cause clears, the reset is released exactly HOLD_MS edges after the first edge that sees no cause. The filtered pushbutton adds one edge of latency to this.
- R5: The select encoding is `2'b00` for WD_SHORT_MS, `2'b01` for WD_MID_MS, and `2'b10` or `2'b11` for WD_LONG_MS. With no strobe falling edge, the reset asserts exactly that many edges after the watchdog starts counting.
- R6: Only a high-to-low strobe transition restarts the watchdog. A strobe that stays high, stays low, or only rises does not change when the reset asserts.
- R7: A pushbutton low that lasts fewer than PB_ACCEPT_MS samples has no effect. Any high sample clears the filter's run count.
- R8: A pushbutton low that lasts PB_ACCEPT_MS consecutive samples asserts the reset one edge later, and the reset stays asserted while the button is held.
- R9: The watchdog count is cleared and held while the reset is asserted, and it starts from zero when the reset is released.
- R10: The watchdog latches the select only when it restarts. A select change made during a count takes effect at the next restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock, one edge per millisecond |
| rst | input | 1 | Synchronous power-on reset, active high |
| uv_n | input | 1 | Undervoltage flag, low while the supply is below threshold |
| button_n | input | 1 | Pushbutton, low while pressed |
| strobe | input | 1 | Watchdog feed; falling edges restart the count |
| wd_sel | input | 2 | Watchdog timeout select |
| sys_reset | output | 1 | System reset, active high |
| sys_reset_n | output | 1 | System reset, active low |

## Verification
The watchdog is tried with every select value and with the strobe parked high, parked low, rising once, or falling at regular intervals. These cases separate a restart on the correct edge from a restart on any level or on the wrong edge, and they also show each timeout length. The pushbutton is driven with a single short low, with broken low runs, and with a long held low, which separates a filter that counts a continuous run from one that accumulates or reacts at once. Each cause is also released after a long reset to measure the hold time and to confirm that the watchdog starts counting fresh after the release.

// File: rtl/sup_pkg.sv
package sup_pkg;

  // Timeout in clock ticks for a given select code.
  function automatic int wd_limit(input logic [1:0] sel, input int t_short,
                                  input int t_mid, input int t_long);
    int r;
    case (sel)
      2'b00:   r = t_short;
      2'b01:   r = t_mid;
      default: r = t_long;
    endcase
    return r;
  endfunction

  // Width of a counter that must hold values 0..n.
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/pb_filter.sv
module pb_filter #(
  parameter int ACCEPT = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic button_n,
  output logic pressed
);
  import sup_pkg::*;
  localparam int CW = cnt_width(ACCEPT);
  localparam logic [CW-1:0] LAST = CW'(ACCEPT - 1);

  logic [CW-1:0] run_cnt;
  logic          run_full;

  assign run_full = (run_cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
      pressed <= 1'b0;
    end else if (button_n) begin
      run_cnt <= '0;
      pressed <= 1'b0;
    end else if (run_full) begin
      pressed <= 1'b1;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  // R8: acceptance only ever follows a low sample
  a_r8_accept_after_low: assert property (@(posedge clk) disable iff (rst)
    $rose(pressed) |-> $past(!button_n));
  // R7: a high sample always drops the filtered press
  a_r7_high_clears: assert property (@(posedge clk) disable iff (rst)
    button_n |=> !pressed);
endmodule

// File: rtl/strobe_watchdog.sv
module strobe_watchdog #(
  parameter int T_SHORT = 150,
  parameter int T_MID   = 600,
  parameter int T_LONG  = 1200,
  parameter int SYNC    = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       strobe,
  input  logic [1:0] sel,
  input  logic       hold,
  output logic       kick,
  output logic       bite
);
  import sup_pkg::*;
  localparam int CW = cnt_width(T_LONG);

  logic [SYNC:0]  strb_sh;
  logic [CW-1:0]  cnt;
  logic [CW-1:0]  lim;
  logic [CW-1:0]  next_lim;
  logic           restart;

  // synchroniser plus one history stage
  always_ff @(posedge clk) begin
    if (rst) strb_sh <= '0;
    else     strb_sh <= {strb_sh[SYNC-1:0], strobe};
  end

  assign kick     = strb_sh[SYNC] & ~strb_sh[SYNC-1];
  assign next_lim = CW'(wd_limit(sel, T_SHORT, T_MID, T_LONG));
  assign restart  = hold | kick;
  assign bite     = !restart && (cnt == lim - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      lim <= next_lim;
    end else if (restart) begin
      cnt <= '0;
      lim <= next_lim;
    end else if (bite) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R9: count held at zero through reset
  a_r9_held_in_reset: assert property (@(posedge clk) disable iff (rst)
    hold |=> (cnt == '0));
  // R6: falling strobe edge restarts the count
  a_r6_kick_restarts: assert property (@(posedge clk) disable iff (rst)
    kick |=> (cnt == '0));
  // R10: limit frozen while counting
  a_r10_limit_frozen: assert property (@(posedge clk) disable iff (rst)
    !restart |=> $stable(lim));
  // R5: never expires while held
  a_r5_no_bite_in_hold: assert property (@(posedge clk) disable iff (rst)
    hold |-> !bite);
endmodule

// File: rtl/reset_stretcher.sv
module reset_stretcher #(
  parameter int HOLD = 250
) (
  input  logic clk,
  input  logic rst,
  input  logic cause,
  output logic active
);
  import sup_pkg::*;
  localparam int CW = cnt_width(HOLD);
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [CW-1:0] hcnt;
  logic          quiet_done;

  assign quiet_done = (hcnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || cause) begin
      active <= 1'b1;
      hcnt   <= '0;
    end else if (active) begin
      if (quiet_done) active <= 1'b0;
      else            hcnt   <= hcnt + 1'b1;
    end
  end

  // R3: an active cause keeps the reset on
  a_r3_cause_holds: assert property (@(posedge clk) disable iff (rst)
    cause |=> active);
  // R4: release only after a quiet edge
  a_r4_release_quiet: assert property (@(posedge clk) disable iff (rst)
    $fell(active) |-> $past(!cause));
endmodule

// File: rtl/supervisor_reset_ctrl.sv
module supervisor_reset_ctrl #(
  parameter int HOLD_MS      = 250,
  parameter int WD_SHORT_MS  = 150,
  parameter int WD_MID_MS    = 600,
  parameter int WD_LONG_MS   = 1200,
  parameter int PB_ACCEPT_MS = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       uv_n,
  input  logic       button_n,
  input  logic       strobe,
  input  logic [1:0] wd_sel,
  output logic       sys_reset,
  output logic       sys_reset_n
);
  logic pb_pressed;
  logic wd_kick;
  logic wd_bite;
  logic any_cause;
  logic stretch_on;

  pb_filter #(.ACCEPT(PB_ACCEPT_MS)) u_pb (
    .clk(clk), .rst(rst), .button_n(button_n), .pressed(pb_pressed)
  );

  strobe_watchdog #(
    .T_SHORT(WD_SHORT_MS), .T_MID(WD_MID_MS), .T_LONG(WD_LONG_MS), .SYNC(2)
  ) u_wd (
    .clk(clk), .rst(rst), .strobe(strobe), .sel(wd_sel), .hold(stretch_on),
    .kick(wd_kick), .bite(wd_bite)
  );

  assign any_cause = !uv_n | pb_pressed | wd_bite;

  reset_stretcher #(.HOLD(HOLD_MS)) u_str (
    .clk(clk), .rst(rst), .cause(any_cause), .active(stretch_on)
  );

  assign sys_reset   = stretch_on;
  assign sys_reset_n = ~stretch_on;

  // R5: an expiry produces a reset at the next edge
  a_r5_bite_resets: assert property (@(posedge clk) disable iff (rst)
    wd_bite |=> sys_reset);
  // R8: an accepted press produces a reset at the next edge
  a_r8_press_resets: assert property (@(posedge clk) disable iff (rst)
    pb_pressed |=> sys_reset);
  // R3: undervoltage produces a reset at the next edge
  a_r3_uv_resets: assert property (@(posedge clk) disable iff (rst)
    !uv_n |=> sys_reset);
endmodule

// File: tb/supervisor_reset_ctrl_test.sv
`timescale 1ns/1ps
module supervisor_reset_ctrl_test;
  localparam int HOLD = 20;
  localparam int TS   = 15;
  localparam int TM   = 30;
  localparam int TL   = 60;
  localparam int PB   = 5;

  typedef struct packed {
    logic [1:0]  sel;
    logic        lvl;
    logic [15:0] exp_cyc;
  } vec_t;

  localparam vec_t VECS [0:5] = '{
    '{2'b00, 1'b1, 16'(TS)},
    '{2'b01, 1'b1, 16'(TM)},
    '{2'b10, 1'b1, 16'(TL)},
    '{2'b11, 1'b0, 16'(TL)},
    '{2'b00, 1'b0, 16'(TS)},
    '{2'b01, 1'b0, 16'(TM)}
  };

  logic clk = 1'b0;
  logic rst, uv_n, button_n, man_strobe, kick_en, kick_sig;
  logic [1:0] wd_sel;
  logic strobe, sys_reset, sys_reset_n;
  int n_chk = 0, n_bad = 0, comp_bad = 0, cyc = 0, kick_div = 0;

  always #2.5 clk = ~clk;

  assign strobe = kick_en ? kick_sig : man_strobe;

  supervisor_reset_ctrl #(
    .HOLD_MS(HOLD), .WD_SHORT_MS(TS), .WD_MID_MS(TM), .WD_LONG_MS(TL),
    .PB_ACCEPT_MS(PB)
  ) uut (
    .clk(clk), .rst(rst), .uv_n(uv_n), .button_n(button_n), .strobe(strobe),
    .wd_sel(wd_sel), .sys_reset(sys_reset), .sys_reset_n(sys_reset_n)
  );

  always @(negedge clk) begin
    kick_div <= (kick_div == 2) ? 0 : kick_div + 1;
    if (kick_div == 2) kick_sig <= ~kick_sig;
    if (sys_reset === sys_reset_n) comp_bad <= comp_bad + 1;
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cyc);
      finish_run();
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic ticks(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  task automatic count_until(input logic lvl, output int n);
    n = 0;
    while (sys_reset !== lvl && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic uv_pulse();
    uv_n = 1'b0; ticks(1); uv_n = 1'b1;
  endtask

  int n, hi_seen;
  logic [1:0] exp_sel_lim;

  initial begin
    rst = 1'b1; uv_n = 1'b1; button_n = 1'b1; man_strobe = 1'b1;
    kick_en = 1'b1; kick_sig = 1'b0; wd_sel = 2'b00;
    ticks(3);
    chk("R1 reset during rst", sys_reset, 1);
    chk("R2 complement during rst", sys_reset_n, 0);
    rst = 1'b0;
    count_until(1'b0, n);
    chk("R1 power-on hold", n, HOLD);

    // R5/R6: walk the table with a static strobe level
    kick_en = 1'b0;
    foreach (VECS[i]) begin
      man_strobe = VECS[i].lvl;
      wd_sel = VECS[i].sel;
      ticks(4);
      uv_pulse();
      count_until(1'b0, n);
      count_until(1'b1, n);
      chk($sformatf("R5 R6 timeout sel=%0d lvl=%0d", VECS[i].sel, VECS[i].lvl),
          n, int'(VECS[i].exp_cyc));
      count_until(1'b0, n);
      chk("R4 hold after watchdog reset", n, HOLD);
    end

    // R6: falling edges keep the watchdog quiet
    wd_sel = 2'b00; man_strobe = 1'b1; ticks(2);
    uv_pulse();
    count_until(1'b0, n);
    hi_seen = 0;
    for (int k = 0; k < 8; k++) begin
      for (int j = 0; j < 5; j++) begin @(negedge clk); hi_seen += sys_reset; end
      man_strobe = 1'b0;
      for (int j = 0; j < 5; j++) begin @(negedge clk); hi_seen += sys_reset; end
      man_strobe = 1'b1;
    end
    chk("R6 falling strobe feeds watchdog", hi_seen, 0);
    count_until(1'b1, n);
    count_until(1'b0, n);

    // R6: a rising edge alone does not restart
    man_strobe = 1'b0; ticks(4);
    uv_pulse();
    count_until(1'b0, n);
    n = 0;
    while (sys_reset !== 1'b1 && n < 5000) begin
      if (n == 7) man_strobe = 1'b1;
      @(negedge clk);
      n++;
    end
    chk("R6 rising strobe ignored", n, TS);
    count_until(1'b0, n);

    // R10: select change waits for next restart
    man_strobe = 1'b1; wd_sel = 2'b00; ticks(4);
    uv_pulse();
    count_until(1'b0, n);
    n = 0;
    while (sys_reset !== 1'b1 && n < 5000) begin
      if (n == 5) wd_sel = 2'b10;
      @(negedge clk);
      n++;
    end
    chk("R10 old select still in force", n, TS);
    count_until(1'b0, n);
    count_until(1'b1, n);
    chk("R10 new select after restart", n, TL);
    count_until(1'b0, n);

    // R9/R4: long undervoltage, then full count from release
    wd_sel = 2'b00;
    uv_n = 1'b0; ticks(1);
    chk("R3 undervoltage asserts next edge", sys_reset, 1);
    ticks(100);
    chk("R3 held while undervoltage", sys_reset, 1);
    uv_n = 1'b1;
    count_until(1'b0, n);
    chk("R4 hold after undervoltage", n, HOLD);
    count_until(1'b1, n);
    chk("R9 watchdog counts fresh after release", n, TS);
    count_until(1'b0, n);

    // pushbutton tests with the watchdog fed
    kick_en = 1'b1; ticks(6);
    button_n = 1'b0; ticks(PB - 1); button_n = 1'b1;
    hi_seen = 0;
    for (int j = 0; j < 10; j++) begin @(negedge clk); hi_seen += sys_reset; end
    chk("R7 short press ignored", hi_seen, 0);
    for (int k = 0; k < 3; k++) begin
      button_n = 1'b0; ticks(PB - 2); button_n = 1'b1; ticks(1);
    end
    hi_seen = 0;
    for (int j = 0; j < 10; j++) begin @(negedge clk); hi_seen += sys_reset; end
    chk("R7 broken runs ignored", hi_seen, 0);

    button_n = 1'b0;
    count_until(1'b1, n);
    chk("R8 press accepted latency", n, PB + 1);
    ticks(80);
    chk("R8 held while pressed", sys_reset, 1);
    button_n = 1'b1;
    count_until(1'b0, n);
    chk("R4 hold after button", n, HOLD + 1);

    chk("R2 outputs complementary", comp_bad, 0);
    finish_run();
  end
endmodule